// File: doc/BRIEF.md
# Multidrop Wake-Up Framing Unit

This block adds multidrop addressing to an existing asynchronous serial transmitter and receiver pair. Many nodes share one line. Each block of frames opens with an address frame, and only the node that owns that address handles the data frames that follow. The shift registers, the start-edge detector and the baud generator sit outside this unit. They report one pulse per bit period (`bitTick`), the start of each received frame, its completion, and the free or busy state of the transmit shift register.

A single mode input selects one of two schemes. In idle-line mode, a received frame counts as an address when the line stayed high for at least ten whole bit periods before its start edge. On transmit, an armed wake request holds the next frame back for exactly eleven idle bit periods. In address-bit mode, every frame carries one extra bit after its data bits. A 1 in that bit marks an address and a 0 marks data. An armed wake request sets that bit on the next frame loaded, and the length of the idle gap carries no meaning.

While sleep is enabled, the receive-ready pulse appears only for address frames. A wake-detected flag records that the most recent frame was an address. Comparing the received address with the node's own address is left to software.

Top module: `wake_frame_unit`

## Requirements
- R1: `addrBitMode` = 0 selects idle-line classification and gap insertion; `addrBitMode` = 1 selects classification and marking by the extra frame bit. Changing the mode changes how the next frame is handled.
- R2: In idle-line mode, an idle count rises by one on each `bitTick` cycle with `rxLine` = 1, saturates at 10, and returns to 0 on any cycle with `rxLine` = 0. A frame is an address when the count is 10 in its `rxStart` cycle. A gap of 9 ticks gives a data frame.
- R3: In address-bit mode, a frame is an address exactly when `rxAddrBit` = 1 in its `rxDone` cycle.
- R4: `rxAddrFrame` pulses for one cycle, the cycle after `rxDone`, when the completed frame is an address.
- R5: `rxReady` pulses for one cycle, the cycle after `rxDone`, when `sleepEn` = 0 or the frame is an address. With `sleepEn` = 1 and a data frame, it stays 0.
- R6: `wakeFlag` becomes 1 after an address frame and 0 after a data frame, each from the cycle after `rxDone`. It also returns to 0 in the cycle after `sleepEn` falls from 1 to 0, and that clear wins over a coincident frame.
- R7: With no idle gap needed, `txLoad` is high for one cycle, in the cycle after the first clock edge that sees `txBufValid` = 1 and `txShiftIdle` = 1. All outputs are 0 after reset.
- R8: In idle-line mode with the wake request armed, that edge starts a gap instead. `txLoad` is then high in the cycle right after the 11th `bitTick` that follows the gap start.
- R9: `txFrameAddr` is high together with `txLoad` when the mode is address-bit and the wake request was armed, with no gap inserted. In idle-line mode it stays 0.
- R10: `txWakeSet` arms `txWakeArmed` from the next cycle. A load clears it. A set in the same cycle as a load wins, and that set applies to the following frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| addrBitMode | input | 1 | 0 = idle-line scheme, 1 = address-bit scheme |
| sleepEn | input | 1 | Sleep: hide receive-ready for data frames |
| bitTick | input | 1 | One-cycle pulse per bit period |
| rxLine | input | 1 | Receive line level |
| rxStart | input | 1 | Pulse on a received frame's start edge |
| rxDone | input | 1 | Pulse when a received frame completes |
| rxAddrBit | input | 1 | Extra frame bit of the completed frame |
| txWakeSet | input | 1 | Arm the transmit wake request |
| txBufValid | input | 1 | A byte waits in the transmit buffer |
| txShiftIdle | input | 1 | Transmit shift register is free |
| txLoad | output | 1 | Move the buffered byte into the shift register |
| txFrameAddr | output | 1 | Extra bit value for the frame being loaded |
| txWakeArmed | output | 1 | Transmit wake request pending |
| rxReady | output | 1 | Receive-ready pulse after sleep filtering |
| rxAddrFrame | output | 1 | Completed frame was an address |
| wakeFlag | output | 1 | Wake condition detected |

## Verification
Every receive result falls due exactly one cycle after its `rxDone` pulse. A plain `txLoad` follows one cycle after the ready edge, while a gapped load lands in the cycle right after the eleventh bit tick. A behavioural reference model in the bench advances on the same rising edge that the design uses and predicts all six outputs. The outputs are compared with the model on every falling edge, so each result is checked in the one cycle it is due and in every cycle on either side. The stimulus covers 9-tick and 10-tick idle gaps, sleep on and off, both modes, and a wake set that coincides with a load.

// File: rtl/wake_pkg.sv
package wake_pkg;
  // Strobes sent by the control to the datapath counters
  typedef struct packed {
    logic gapClr;
    logic gapInc;
    logic latchIdle;
  } dpCtl_t;

  typedef enum logic {TX_WAIT, TX_GAP} txState_t;
endpackage

// File: rtl/wake_dp.sv
module wake_dp
  import wake_pkg::*;
#(
  parameter int IDLE_BITS = 10,
  parameter int GAP_BITS  = 11
) (
  input  logic   clk,
  input  logic   rstN,
  input  dpCtl_t ctl,
  input  logic   bitTick,
  input  logic   rxLine,
  output logic   idleAddr,
  output logic   gapLast
);
  localparam int IW = $clog2(IDLE_BITS + 1);
  localparam int GW = $clog2(GAP_BITS + 1);
  localparam logic [IW-1:0] IDLE_MAX = IW'(IDLE_BITS);
  localparam logic [GW-1:0] GAP_END  = GW'(GAP_BITS - 1);

  logic [IW-1:0] idleCnt;
  logic [GW-1:0] gapCnt;

  // Whole bit periods of continuous high line, saturating
  always_ff @(posedge clk) begin
    if (!rstN)                              idleCnt <= '0;
    else if (!rxLine)                       idleCnt <= '0;
    else if (bitTick && idleCnt != IDLE_MAX) idleCnt <= idleCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)              idleAddr <= 1'b0;
    else if (ctl.latchIdle) idleAddr <= (idleCnt == IDLE_MAX);
  end

  always_ff @(posedge clk) begin
    if (!rstN)           gapCnt <= '0;
    else if (ctl.gapClr) gapCnt <= '0;
    else if (ctl.gapInc) gapCnt <= gapCnt + 1'b1;
  end

  assign gapLast = (gapCnt == GAP_END);

  p_idle_sat_r2: assert property (@(posedge clk) disable iff (!rstN)
    idleCnt <= IDLE_MAX);

  p_idle_count_r2: assert property (@(posedge clk) disable iff (!rstN)
    (rxLine && bitTick && idleCnt < IDLE_MAX) |=> idleCnt == $past(idleCnt) + 1'b1);
endmodule

// File: rtl/wake_ctrl.sv
module wake_ctrl
  import wake_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   addrBitMode,
  input  logic   sleepEn,
  input  logic   bitTick,
  input  logic   rxStart,
  input  logic   rxDone,
  input  logic   rxAddrBit,
  input  logic   txWakeSet,
  input  logic   txBufValid,
  input  logic   txShiftIdle,
  input  logic   idleAddr,
  input  logic   gapLast,
  output dpCtl_t ctl,
  output logic   txLoad,
  output logic   txFrameAddr,
  output logic   txWakeArmed,
  output logic   rxReady,
  output logic   rxAddrFrame,
  output logic   wakeFlag
);
  txState_t txState, txNext;
  logic loadNow, readyToMove, isAddr, sleepPrev, sleepFall;

  assign readyToMove = txBufValid && txShiftIdle && !txLoad;

  always_comb begin
    loadNow       = 1'b0;
    txNext        = txState;
    ctl           = '0;
    ctl.latchIdle = rxStart;
    case (txState)
      TX_WAIT: if (readyToMove) begin
        if (txWakeArmed && !addrBitMode) begin
          ctl.gapClr = 1'b1;
          txNext     = TX_GAP;
        end else loadNow = 1'b1;
      end
      TX_GAP: if (bitTick) begin
        if (gapLast) begin
          loadNow = 1'b1;
          txNext  = TX_WAIT;
        end else ctl.gapInc = 1'b1;
      end
      default: txNext = TX_WAIT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txState     <= TX_WAIT;
      txLoad      <= 1'b0;
      txFrameAddr <= 1'b0;
      txWakeArmed <= 1'b0;
    end else begin
      txState     <= txNext;
      txLoad      <= loadNow;
      txFrameAddr <= loadNow && addrBitMode && txWakeArmed;
      txWakeArmed <= txWakeSet || (txWakeArmed && !loadNow);
    end
  end

  assign isAddr    = addrBitMode ? rxAddrBit : idleAddr;
  assign sleepFall = sleepPrev && !sleepEn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxReady     <= 1'b0;
      rxAddrFrame <= 1'b0;
      wakeFlag    <= 1'b0;
      sleepPrev   <= 1'b0;
    end else begin
      rxReady     <= rxDone && (!sleepEn || isAddr);
      rxAddrFrame <= rxDone && isAddr;
      sleepPrev   <= sleepEn;
      if (sleepFall)   wakeFlag <= 1'b0;
      else if (rxDone) wakeFlag <= isAddr;
    end
  end

  p_load_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    txLoad |=> !txLoad);

  p_wake_clear_r10: assert property (@(posedge clk) disable iff (!rstN)
    (txLoad && !$past(txWakeSet)) |-> !txWakeArmed);

  p_idle_no_mark_r9: assert property (@(posedge clk) disable iff (!rstN)
    (txLoad && !$past(addrBitMode)) |-> !txFrameAddr);

  p_sleep_block_r5: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rxDone) && $past(sleepEn) && !rxAddrFrame) |-> !rxReady);

  p_wake_rise_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wakeFlag) |-> rxAddrFrame);
endmodule

// File: rtl/wake_frame_unit.sv
module wake_frame_unit
  import wake_pkg::*;
#(
  parameter int IDLE_BITS = 10,
  parameter int GAP_BITS  = 11
) (
  input  logic clk,
  input  logic rstN,
  input  logic addrBitMode,
  input  logic sleepEn,
  input  logic bitTick,
  input  logic rxLine,
  input  logic rxStart,
  input  logic rxDone,
  input  logic rxAddrBit,
  input  logic txWakeSet,
  input  logic txBufValid,
  input  logic txShiftIdle,
  output logic txLoad,
  output logic txFrameAddr,
  output logic txWakeArmed,
  output logic rxReady,
  output logic rxAddrFrame,
  output logic wakeFlag
);
  dpCtl_t ctl;
  logic   idleAddr, gapLast;

  wake_dp #(.IDLE_BITS(IDLE_BITS), .GAP_BITS(GAP_BITS)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .bitTick(bitTick), .rxLine(rxLine),
    .idleAddr(idleAddr), .gapLast(gapLast)
  );

  wake_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .addrBitMode(addrBitMode), .sleepEn(sleepEn),
    .bitTick(bitTick), .rxStart(rxStart), .rxDone(rxDone), .rxAddrBit(rxAddrBit),
    .txWakeSet(txWakeSet), .txBufValid(txBufValid), .txShiftIdle(txShiftIdle),
    .idleAddr(idleAddr), .gapLast(gapLast), .ctl(ctl),
    .txLoad(txLoad), .txFrameAddr(txFrameAddr), .txWakeArmed(txWakeArmed),
    .rxReady(rxReady), .rxAddrFrame(rxAddrFrame), .wakeFlag(wakeFlag)
  );
endmodule

// File: tb/wake_frame_unit_test.sv
`timescale 1ns/1ps
module wake_frame_unit_test;
  logic clk = 1'b0, rstN = 1'b0;
  logic addrBitMode = 0, sleepEn = 0, bitTick = 0, rxLine = 1, rxStart = 0;
  logic rxDone = 0, rxAddrBit = 0, txWakeSet = 0, txBufValid = 0, txShiftIdle = 1;
  logic txLoad, txFrameAddr, txWakeArmed, rxReady, rxAddrFrame, wakeFlag;

  int compared = 0, mismatched = 0, tc = 0;
  bit finished = 0;
  string phase = "R7 reset";

  // reference model state
  int mIdle = 0, mGap = 0, mState = 0;
  bit mIdleAddr = 0, mArmed = 0, mLoad = 0, mFA = 0;
  bit mReady = 0, mAF = 0, mWake = 0, mSleepPrev = 0, ld = 0, isA = 0;

  always #2 clk = ~clk;

  wake_frame_unit uut (
    .clk(clk), .rstN(rstN), .addrBitMode(addrBitMode), .sleepEn(sleepEn),
    .bitTick(bitTick), .rxLine(rxLine), .rxStart(rxStart), .rxDone(rxDone),
    .rxAddrBit(rxAddrBit), .txWakeSet(txWakeSet), .txBufValid(txBufValid),
    .txShiftIdle(txShiftIdle), .txLoad(txLoad), .txFrameAddr(txFrameAddr),
    .txWakeArmed(txWakeArmed), .rxReady(rxReady), .rxAddrFrame(rxAddrFrame),
    .wakeFlag(wakeFlag)
  );

  // bit period of four clocks
  always @(negedge clk) begin
    if (!rstN) begin tc <= 0; bitTick <= 0; end
    else begin tc <= (tc == 3) ? 0 : tc + 1; bitTick <= (tc == 3); end
  end

  // behavioural reference, advanced on the design's edge
  always @(posedge clk) begin
    if (!rstN) begin
      mIdle = 0; mGap = 0; mState = 0; mIdleAddr = 0; mArmed = 0; mLoad = 0;
      mFA = 0; mReady = 0; mAF = 0; mWake = 0; mSleepPrev = 0;
    end else begin
      ld = 0;
      if (mState == 0) begin
        if (txBufValid && txShiftIdle && !mLoad) begin
          if (mArmed && !addrBitMode) begin mState = 1; mGap = 0; end
          else ld = 1;
        end
      end else if (bitTick) begin
        mGap++;
        if (mGap == 11) begin ld = 1; mState = 0; end
      end
      mFA = ld && addrBitMode && mArmed;
      mArmed = txWakeSet || (mArmed && !ld);
      mLoad = ld;
      isA = addrBitMode ? rxAddrBit : mIdleAddr;
      mReady = rxDone && (!sleepEn || isA);
      mAF = rxDone && isA;
      if (mSleepPrev && !sleepEn) mWake = 0;
      else if (rxDone) mWake = isA;
      mSleepPrev = sleepEn;
      if (rxStart) mIdleAddr = (mIdle >= 10);
      if (!rxLine) mIdle = 0;
      else if (bitTick && mIdle < 10) mIdle++;
    end
  end

  task automatic cmp(string name, logic act, bit exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s at %0t: actual=%b expected=%b", phase, name, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!finished) begin
      cmp("txLoad R7/R8", txLoad, mLoad);
      cmp("txFrameAddr R9", txFrameAddr, mFA);
      cmp("txWakeArmed R10", txWakeArmed, mArmed);
      cmp("rxReady R5", rxReady, mReady);
      cmp("rxAddrFrame R4", rxAddrFrame, mAF);
      cmp("wakeFlag R6", wakeFlag, mWake);
    end
  end

  task automatic waitTicks(int n);
    int k = 0;
    while (k < n) begin
      @(posedge clk); if (bitTick) k++;
      @(negedge clk); rxDone = 0; rxAddrBit = 0;
    end
  endtask

  task automatic rxFrame(int gap, bit ab);
    rxLine = 1;
    waitTicks(gap);
    rxLine = 0; rxStart = 1;
    @(negedge clk) rxStart = 0;
    repeat (6) @(negedge clk);
    rxDone = 1; rxAddrBit = ab; rxLine = 1;
  endtask

  task automatic sendByte(bit arm, bit setWithLoad);
    if (arm) begin txWakeSet = 1; @(negedge clk) txWakeSet = 0; end
    txBufValid = 1;
    if (setWithLoad) txWakeSet = 1;
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      txWakeSet = 0;
      if (txLoad) break;
    end
    txBufValid = 0; txShiftIdle = 0;
    repeat (12) @(negedge clk);
    txShiftIdle = 1;
    repeat (3) @(negedge clk);
  endtask

  task automatic summary;
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    repeat (2) @(negedge clk);
    // idle-line receive with sleep
    phase = "R2 idle-line 12-tick gap address"; addrBitMode = 0; sleepEn = 1;
    rxFrame(12, 0);
    phase = "R2 idle-line 3-tick gap data"; rxFrame(3, 0);
    phase = "R2 idle-line 10-tick gap address"; rxFrame(10, 0);
    phase = "R2 idle-line 9-tick gap data"; rxFrame(9, 0);
    phase = "R5 idle-line address bit ignored"; rxFrame(2, 1);
    phase = "R6 sleep fall clears"; rxFrame(11, 0);
    waitTicks(2); sleepEn = 0; waitTicks(2);
    phase = "R5 awake data ready"; rxFrame(4, 0);
    // address-bit receive
    phase = "R1 switch to address-bit"; addrBitMode = 1; sleepEn = 1;
    rxFrame(11, 0);
    phase = "R3 address-bit address"; rxFrame(1, 1);
    phase = "R3 address-bit data"; rxFrame(1, 0);
    phase = "R4 address-bit address again"; rxFrame(1, 1);
    phase = "R6 sleep fall with frame"; rxFrame(1, 0);
    sleepEn = 0; waitTicks(3);
    // transmit
    phase = "R7 idle-line plain load"; addrBitMode = 0; sendByte(0, 0);
    phase = "R8 idle-line 11-bit gap"; sendByte(1, 0);
    phase = "R9 address-bit marked load"; addrBitMode = 1; sendByte(1, 0);
    phase = "R10 set with load"; sendByte(0, 1);
    phase = "R9 carried arm marks next"; sendByte(0, 0);
    phase = "R1 back to idle-line gap"; addrBitMode = 0; sendByte(1, 1);
    repeat (10) @(negedge clk);
    summary();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL R7 watchdog: actual=hung expected=finished");
      summary();
    end
  end
endmodule